// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 41 maskable request lines. Each line has an enable bit, a pending bit and a 4-bit priority. A lower priority value is more urgent. From the lines that are both pending and enabled, the controller picks the most urgent one. It compares that choice against the level of the handler now running. If the request wins, the controller opens an entry window that stands in for saving processor state. At the end of the window it hands the core the winning channel number together with a one-cycle start strobe.

A request that arrives during the window with a strictly more urgent priority takes over the entry. The window is not restarted, so only one start strobe is given. Nested handlers are tracked on a stack of active priorities, 16 deep. When the core signals a handler return, the controller checks whether any enabled pending request beats the level the return would restore. If one does, it chains straight into that request through a short window and skips the full window. If none does, it restores the previous level.

Software drives a small configuration port that writes enables and priorities, and that sets or clears pending bits. A separate read port returns the state of any one channel.

Top module: `vic_core`

## Requirements
- R1: After reset every channel is disabled, not pending and at priority 0. `level_o` is 16 (base level, nothing active), `depth_o` is 0, and `start_o` and `entry_busy_o` are low.
- R2: A high `irq_i` bit at a clock edge sets that channel's pending bit. Configuration op 1 sets a pending bit and op 2 clears it. If a set and a clear reach the same channel in the same cycle, the set wins. Op 0 writes the enable from `cfg_val[0]` and op 3 writes the priority. Every change is visible on the read port one cycle after the edge.
- R3: A pending channel that is disabled never starts an entry, and its pending bit stays set.
- R4: Among pending, enabled channels, the lowest priority value wins. On a tie, the lowest channel number wins.
- R5: A qualifying request starts an entry at the next edge. `start_o` pulses for one cycle 12 cycles later, with `vec_o` set to the channel. The channel's pending bit clears at that same edge. For a request sampled at edge A, the start appears at edge A+13.
- R6: During the entry window, a request with a strictly lower priority value replaces the channel being entered and the strobe timing does not change. A request of equal priority does not replace it. Exactly one start is given.
- R7: A new entry begins only if its priority value is strictly below `level_o`. Each completed entry raises `depth_o` by one and sets `level_o` to the new priority.
- R8: A `core_ret_i` pulse that arrives with no entry in progress and `depth_o` > 0, and with no chain possible, lowers `depth_o` by one and restores the preempted level, or 16 at depth 0.
- R9: On a return, if an enabled pending request has a priority value strictly below the level that would be restored, the controller chains into it. The start strobe arrives 2 cycles after the return edge, `depth_o` stays the same, and `level_o` becomes the chained priority.
- R10: `core_ret_i` has no effect while an entry is in progress or while `depth_o` is 0.
- R11: The level of an active handler is the priority captured at its entry. Rewriting that channel's priority afterwards changes neither `level_o` nor the level that a later return restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 41 | Request lines, one per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 enable, 1 set pending, 2 clear pending, 3 priority |
| cfg_idx | input | 6 | Target channel; values of 41 and above are ignored |
| cfg_val | input | 4 | Priority value, or the enable in bit 0 |
| rd_idx | input | 6 | Channel selected for readback |
| rd_en_o | output | 1 | Enable of the selected channel |
| rd_pend_o | output | 1 | Pending bit of the selected channel |
| rd_prio_o | output | 4 | Priority of the selected channel |
| core_ret_i | input | 1 | Handler return pulse from the core |
| entry_busy_o | output | 1 | Entry or chain window in progress |
| start_o | output | 1 | One-cycle handler start strobe |
| vec_o | output | 6 | Channel number being started |
| level_o | output | 5 | Current execution priority; 16 means base level |
| depth_o | output | 5 | Number of nested active handlers |

## Verification
Pending and configuration changes show on the read port one cycle after the edge that samples them. A normal start is due 13 edges after the request edge. A chained start is due 2 edges after the return edge. A late replacement leaves the original 13-edge schedule unchanged. The bench drives every stimulus on a falling edge and counts falling edges until the strobe appears, so the check compares an exact count against 13, 2, or the remainder of a window that is already running. The checks on level and depth are sampled at that same falling edge, because both registers update on the strobe edge.

// File: rtl/vic_core.sv
`timescale 1ns/1ps
module vic_core #(
  parameter int N         = 41,
  parameter int PW        = 4,
  parameter int ENTRY_CYC = 12,
  parameter int TAIL_CYC  = 2,
  parameter int NEST      = 16,
  localparam int IW = $clog2(N),
  localparam int DW = $clog2(NEST + 1),
  localparam int SW = $clog2(NEST),
  localparam int CW = $clog2(ENTRY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_i,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_op,
  input  logic [IW-1:0] cfg_idx,
  input  logic [PW-1:0] cfg_val,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_en_o,
  output logic          rd_pend_o,
  output logic [PW-1:0] rd_prio_o,
  input  logic          core_ret_i,
  output logic          entry_busy_o,
  output logic          start_o,
  output logic [IW-1:0] vec_o,
  output logic [PW:0]   level_o,
  output logic [DW-1:0] depth_o
);
  localparam logic [PW:0] BASE = {1'b1, {PW{1'b0}}};

  logic [N-1:0]  en_q, pend_q;
  logic [PW-1:0] prio_q [N];
  logic [PW-1:0] stk [NEST];
  logic [DW-1:0] depth_q;
  logic          busy_q, chain_q, go_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] ent_ch_q, vec_q;
  logic [PW-1:0] ent_p_q;

  wire idx_ok = 32'(cfg_idx) < N;
  wire rd_ok  = 32'(rd_idx) < N;

  logic          best_ok;
  logic [IW-1:0] best_ch;
  logic [PW-1:0] best_p;
  always_comb begin
    best_ok = 1'b0;
    best_ch = '0;
    best_p  = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i] && en_q[i] && (!best_ok || prio_q[i] <= best_p)) begin
        best_ok = 1'b1;
        best_ch = IW'(i);
        best_p  = prio_q[i];
      end
    end
  end

  wire [PW:0] level = (depth_q == '0) ? BASE : {1'b0, stk[SW'(depth_q - 1'b1)]};
  wire [PW:0] under = (depth_q > DW'(1)) ? {1'b0, stk[SW'(depth_q - DW'(2))]} : BASE;

  wire ret_ok    = core_ret_i && !busy_q && depth_q != '0;
  wire chain_now = ret_ok && best_ok && ({1'b0, best_p} < under);
  wire start_new = !busy_q && !ret_ok && best_ok && ({1'b0, best_p} < level)
                   && depth_q < DW'(NEST);
  wire late      = busy_q && best_ok && best_p < ent_p_q;

  wire [IW-1:0] nxt_ch = late ? best_ch : ent_ch_q;
  wire [PW-1:0] nxt_p  = late ? best_p  : ent_p_q;
  wire [CW-1:0] lim_m1 = chain_q ? CW'(TAIL_CYC - 1) : CW'(ENTRY_CYC - 1);
  wire          fin    = busy_q && cnt_q == lim_m1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic hit, set_i, clr_i;
        hit   = cfg_we && idx_ok && cfg_idx == IW'(i);
        set_i = irq_i[i] || (hit && cfg_op == 2'd1);
        clr_i = (hit && cfg_op == 2'd2) || (fin && nxt_ch == IW'(i));
        pend_q[i] <= (pend_q[i] && !clr_i) || set_i;
        if (hit && cfg_op == 2'd0) en_q[i] <= cfg_val[0];
        if (hit && cfg_op == 2'd3) prio_q[i] <= cfg_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q  <= '0;
      busy_q   <= 1'b0;
      chain_q  <= 1'b0;
      go_q     <= 1'b0;
      cnt_q    <= '0;
      ent_ch_q <= '0;
      ent_p_q  <= '0;
      vec_q    <= '0;
      for (int i = 0; i < NEST; i++) stk[i] <= '0;
    end else begin
      go_q <= 1'b0;
      if (!busy_q) begin
        if (chain_now || start_new) begin
          busy_q   <= 1'b1;
          chain_q  <= chain_now;
          cnt_q    <= '0;
          ent_ch_q <= best_ch;
          ent_p_q  <= best_p;
        end else if (ret_ok) begin
          depth_q <= depth_q - 1'b1;
        end
      end else begin
        ent_ch_q <= nxt_ch;
        ent_p_q  <= nxt_p;
        cnt_q    <= cnt_q + 1'b1;
        if (fin) begin
          busy_q <= 1'b0;
          go_q   <= 1'b1;
          vec_q  <= nxt_ch;
          if (chain_q) begin
            stk[SW'(depth_q - 1'b1)] <= nxt_p;
          end else begin
            stk[SW'(depth_q)] <= nxt_p;
            depth_q <= depth_q + 1'b1;
          end
        end
      end
    end
  end

  assign rd_en_o      = rd_ok ? en_q[rd_idx]   : 1'b0;
  assign rd_pend_o    = rd_ok ? pend_q[rd_idx] : 1'b0;
  assign rd_prio_o    = rd_ok ? prio_q[rd_idx] : '0;
  assign entry_busy_o = busy_q;
  assign start_o      = go_q;
  assign vec_o        = vec_q;
  assign level_o      = level;
  assign depth_o      = depth_q;
endmodule

// File: rtl/vic_core_chk.sv
`timescale 1ns/1ps
module vic_core_chk #(
  parameter int PW   = 4,
  parameter int DW   = 5,
  parameter int NEST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_o,
  input logic          entry_busy_o,
  input logic [PW:0]   level_o,
  input logic [DW-1:0] depth_o
);
  localparam logic [PW:0] BASE = {1'b1, {PW{1'b0}}};

  p_start_from_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(entry_busy_o));

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_start_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !level_o[PW] && depth_o != '0);

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DW'(NEST));

  p_push_more_urgent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o > $past(depth_o)) |-> (level_o < $past(level_o)));

  p_depth_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == $past(depth_o)) || (depth_o == $past(depth_o) + 1'b1)
    || (depth_o + 1'b1 == $past(depth_o)));

  p_base_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == '0) |-> (level_o == BASE));

  p_window_holds_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(entry_busy_o) && entry_busy_o) |-> $stable(depth_o));
endmodule

bind vic_core vic_core_chk #(.PW(PW), .DW(DW), .NEST(NEST)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_o(start_o), .entry_busy_o(entry_busy_o),
  .level_o(level_o), .depth_o(depth_o));

// File: tb/sim_vic_core.sv
`timescale 1ns/1ps
module sim_vic_core;
  localparam int N = 41, PW = 4, IW = 6, DW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic cfg_we = 1'b0, core_ret = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [IW-1:0] cfg_idx = '0, rd_idx = '0;
  logic [PW-1:0] cfg_val = '0;
  logic rd_en, rd_pend, busy, start;
  logic [PW-1:0] rd_prio;
  logic [IW-1:0] vec;
  logic [PW:0] level;
  logic [DW-1:0] depth;

  vic_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val), .rd_idx(rd_idx), .rd_en_o(rd_en),
    .rd_pend_o(rd_pend), .rd_prio_o(rd_prio), .core_ret_i(core_ret),
    .entry_busy_o(busy), .start_o(start), .vec_o(vec), .level_o(level),
    .depth_o(depth));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit b_en [N];
  bit b_pend [N];
  int b_prio [N];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int op, input int idx, input int val);
    cfg_we = 1'b1; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_val = PW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_irq(input int ch);
    irq[ch] = 1'b1;
    @(negedge clk);
    irq = '0;
  endtask

  task automatic pulse_ret();
    core_ret = 1'b1;
    @(negedge clk);
    core_ret = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_start(input int lim, output int n);
    int k = 0;
    n = 0;
    while (n == 0 && k < lim) begin
      @(negedge clk);
      k++;
      if (start) n = k;
    end
  endtask

  task automatic pend_of(input int ch, output int p);
    rd_idx = IW'(ch);
    #1;
    p = int'(rd_pend);
  endtask

  function automatic int best_of();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (b_pend[i] && b_en[i] && (b < 0 || b_prio[i] < b_prio[b])) b = i;
    return b;
  endfunction

  task automatic enable_at(input int ch, input int p);
    cfg(3, ch, p);
    cfg(0, ch, 1);
  endtask

  initial begin
    #(20.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n, p, bst;
    void'($urandom(32'h5eed1));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 level", int'(level), 16);
    check("R1 depth", int'(depth), 0);
    check("R1 start/busy", int'(start) + int'(busy), 0);
    rd_idx = 6'd40; #1;
    check("R1 ch40 state", int'(rd_en) + int'(rd_pend) + int'(rd_prio), 0);

    // R2 / R3 pending with a disabled channel
    pulse_irq(3);
    pend_of(3, p); check("R2 irq sets pending", p, 1);
    wait_start(20, n); check("R3 disabled no start", n, 0);
    pend_of(3, p); check("R3 pending kept", p, 1);
    cfg(2, 3, 0); pend_of(3, p); check("R2 sw clear", p, 0);
    cfg(1, 3, 0); pend_of(3, p); check("R2 sw set", p, 1);
    cfg(2, 3, 0);
    irq[3] = 1'b1; cfg(2, 3, 0); irq = '0;
    pend_of(3, p); check("R2 set beats clear", p, 1);
    cfg(2, 3, 0);

    // R5 basic entry timing
    enable_at(5, 7);
    pulse_irq(5);
    wait_start(30, n); check("R5 start delay", n, 13);
    check("R5 vector", int'(vec), 5);
    check("R7 level after entry", int'(level), 7);
    check("R7 depth after entry", int'(depth), 1);
    pend_of(5, p); check("R5 pending cleared", p, 0);

    // R7 preemption strictness
    enable_at(9, 7);
    pulse_irq(9);
    wait_start(20, n); check("R7 equal no preempt", n, 0);
    enable_at(12, 3);
    pulse_irq(12);
    wait_start(30, n); check("R7 preempt delay", n, 13);
    check("R7 preempt vector", int'(vec), 12);
    check("R7 nested depth", int'(depth), 2);
    check("R7 nested level", int'(level), 3);

    // R8 return, then R9 tail chain
    pulse_ret();
    check("R8 depth after return", int'(depth), 1);
    check("R8 level restored", int'(level), 7);
    wait_start(5, n); check("R8 no chain at equal level", n, 0);
    pulse_ret();
    wait_start(5, n); check("R9 chain delay", n, 2);
    check("R9 chain vector", int'(vec), 9);
    check("R9 chain depth", int'(depth), 1);
    check("R9 chain level", int'(level), 7);
    pulse_ret();
    check("R8 back to base", int'(level), 16);

    // R6 late arrival of a more urgent request
    enable_at(20, 8);
    enable_at(30, 2);
    pulse_irq(20); idle(3); pulse_irq(30);
    wait_start(20, n); check("R6 late start keeps schedule", n, 9);
    check("R6 late vector", int'(vec), 30);
    check("R6 late level", int'(level), 2);
    pend_of(20, p); check("R6 displaced stays pending", p, 1);
    wait_start(14, n); check("R6 single start", n, 0);
    pulse_ret();
    wait_start(5, n); check("R9 chain to displaced", int'(vec) * 100 + n, 2002);
    pulse_ret();

    // R6 equal-priority late arrival does not replace
    enable_at(2, 5);
    enable_at(1, 5);
    pulse_irq(2); idle(3); pulse_irq(1);
    wait_start(20, n); check("R6 equal late keeps entry", int'(vec), 2);
    pulse_ret();
    wait_start(5, n); check("R9 chain to lower index", int'(vec), 1);
    pulse_ret();

    // R4 tie on simultaneous requests
    enable_at(8, 6);
    enable_at(4, 6);
    irq[8] = 1'b1; irq[4] = 1'b1; idle(1); irq = '0;
    wait_start(20, n); check("R4 tie lowest index", int'(vec), 4);
    pulse_ret();
    wait_start(5, n); check("R4 remaining chained", int'(vec), 8);
    pulse_ret();

    // R10 return ignored at depth 0 and during an entry
    pulse_ret();
    check("R10 ret at depth 0", int'(depth) * 100 + int'(level), 16);
    pulse_irq(5);
    wait_start(30, n);
    pulse_irq(12); idle(4); pulse_ret();
    wait_start(20, n); check("R10 ret during entry ignored", n, 8);
    check("R10 depth kept", int'(depth), 2);
    pulse_ret(); pulse_ret();

    // R11 captured level survives a priority rewrite
    pulse_irq(5);
    wait_start(30, n);
    cfg(3, 5, 0);
    check("R11 level unchanged", int'(level), 7);
    pulse_irq(12);
    wait_start(30, n);
    pulse_ret();
    check("R11 restored captured level", int'(level), 7);
    pulse_ret();

    // R4 / R9 random arbitration through a tail chain
    for (int it = 0; it < 25; it++) begin
      int b;
      for (int c = 0; c < N; c++) begin
        cfg(0, c, 0); cfg(2, c, 0);
        b_en[c] = 1'b0; b_pend[c] = 1'b0; b_prio[c] = 0;
      end
      while (busy || depth != '0) begin
        if (!busy) pulse_ret(); else idle(1);
      end
      b = int'($urandom % N);
      cfg(3, b, 0); cfg(0, b, 1); cfg(1, b, 0);
      wait_start(20, n); check("R5 blocker start", int'(level) * 100 + n, 13);
      b_en[b] = 1'b1; b_prio[b] = 0;
      for (int c = 0; c < N; c++) begin
        int pr = int'($urandom % 16);
        cfg(3, c, pr); b_prio[c] = pr;
        if ($urandom % 4 == 0) begin cfg(1, c, 0); b_pend[c] = 1'b1; end
        b_en[c] = ($urandom % 10) < 7;
        cfg(0, c, int'(b_en[c]));
      end
      bst = best_of();
      pulse_ret();
      wait_start(5, n);
      if (bst >= 0) begin
        check("R9 random chain delay", n, 2);
        check("R4 random winner", int'(vec), bst);
        check("R9 random level", int'(level), b_prio[bst]);
      end else begin
        check("R8 random no chain", n * 100 + int'(depth), 0);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule